// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the three settings that steer a frequency synthesizer's dividers: a 9-bit feedback divide value, a 2-bit output divide code and a 3-bit test-select code. Two paths can write these settings.

The parallel path takes the two divide values from input pins. While its strobe is low, the active settings follow the pins on every system clock. A rising edge on the strobe freezes the values present at that edge. The serial path runs only while the parallel strobe is high. A serial clock shifts a data line into a 14-bit register. A falling edge on a separate commit strobe then copies that register into the active settings. Only the serial path can set the test-select code, and that code is cleared whenever the parallel strobe is low.

All strobes are sampled in the system clock domain. Their edges are found by comparing each strobe with its value registered one clock earlier. Each update therefore reaches the outputs on the system clock edge at which the new level is first sampled.

Top module: `divcfg_loader`

## Requirements
- R1: A synchronous reset (`rst` high) clears the feedback value, the output code, the test code and every shift-register bit, so `ser_out` reads 0.
- R2: On every clock edge at which `par_load` is sampled low, `fb_div` takes the `fb_pin` value and `out_div` takes the `out_pin` value.
- R3: On the first clock edge at which `par_load` is sampled high after being low, `fb_div` and `out_div` take the pins. After that, while `par_load` stays high, pin changes have no effect on them.
- R4: On every clock edge at which `par_load` is sampled low, `tst_sel` becomes 000. The parallel path never writes a nonzero test code.
- R5: While `par_load` is high, each clock edge at which `ser_clk` is first sampled high shifts `ser_dat` into bit 0 of the 14-bit register. Every other bit moves up one place, and `ser_out` shows bit 13.
- R6: While `par_load` is low, serial clock edges leave the shift register unchanged.
- R7: While `par_load` is high and steady, a clock edge at which `ser_load` is first sampled low after being high commits the register. Bits [13:11] go to `tst_sel`, bits [10:9] to `out_div` and bits [8:0] to `fb_div`. In the stream this means the test code comes first, then the output code, then the feedback value, each most significant bit first.
- R8: If a commit edge occurs while `par_load` is low, the parallel path wins. The active settings take the pins, and the test code becomes 000.
- R9: A commit leaves the shift register unchanged, so the same stream can be committed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_load | input | 1 | Parallel strobe: low means follow the pins, a rising edge captures them |
| fb_pin | input | 9 | Parallel feedback divide value |
| out_pin | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock, sampled in the system domain |
| ser_dat | input | 1 | Serial data line |
| ser_load | input | 1 | Serial commit strobe, acts on its falling edge |
| fb_div | output | 9 | Active feedback divide value |
| out_div | output | 2 | Active output divide code |
| tst_sel | output | 3 | Active test-select code |
| ser_out | output | 1 | Most significant shift-register bit |

## Verification
The main function is driven with pin patterns that change every cycle while the strobe is low. This separates tracking from capture. The pins then change after the strobe rises, which shows whether the held values really freeze. Two serial streams with asymmetric bit patterns (101/10/1A5 and 011/01/0C3) show whether any field is misplaced or bit-reversed. Serial clocks sent while the strobe is low, a repeated commit, and a commit that coincides with the strobe falling show the gating and the priority between the two paths.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;

  typedef enum logic [1:0] {
    UPD_HOLD    = 2'd0,
    UPD_FLOW    = 2'd1,
    UPD_CAPTURE = 2'd2,
    UPD_SERIAL  = 2'd3
  } upd_src_e;

  function automatic logic rose_now(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic fell_now(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

  // Parallel path has priority over any serial commit.
  function automatic upd_src_e pick_source(input logic par_lvl,
                                           input logic par_rise,
                                           input logic commit);
    if (!par_lvl)      return UPD_FLOW;
    else if (par_rise) return UPD_CAPTURE;
    else if (commit)   return UPD_SERIAL;
    else               return UPD_HOLD;
  endfunction

endpackage

// File: rtl/divcfg_edge.sv
module divcfg_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  import divcfg_pkg::*;

  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = rose_now(lvl[i], lvl_q[i]);
    assign fall[i] = fell_now(lvl[i], lvl_q[i]);

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]); // R5
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      fall[i] |=> !fall[i]); // R7
  end

endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic           step,
  input  logic           din,
  output logic [T_W-1:0] t_f,
  output logic [N_W-1:0] n_f,
  output logic [M_W-1:0] m_f,
  output logic           msb
);
  localparam int SR_W = M_W + N_W + T_W;
  localparam int M_LO = 0;
  localparam int N_LO = M_W;
  localparam int T_LO = M_W + N_W;

  logic [SR_W-1:0] sr;
  logic            do_shift;

  assign do_shift = enable & step;

  function automatic logic [SR_W-1:0] shift_in(input logic [SR_W-1:0] cur,
                                               input logic bit_in);
    return {cur[SR_W-2:0], bit_in};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (do_shift) sr <= shift_in(sr, din);
  end

  assign m_f = sr[M_LO +: M_W];
  assign n_f = sr[N_LO +: N_W];
  assign t_f = sr[T_LO +: T_W];
  assign msb = sr[SR_W-1];

  AST_FROZEN_WHEN_PAR: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(sr)); // R6
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    (enable && step) |=> (sr[0] == $past(din)) &&
                         (sr[SR_W-1:1] == $past(sr[SR_W-2:0]))); // R5
  AST_NO_STEP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sr)); // R9

endmodule

// File: rtl/divcfg_active.sv
module divcfg_active #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_lvl,
  input  logic           par_rise,
  input  logic           commit,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic [T_W-1:0] t_f,
  input  logic [N_W-1:0] n_f,
  input  logic [M_W-1:0] m_f,
  output logic [M_W-1:0] m_act,
  output logic [N_W-1:0] n_act,
  output logic [T_W-1:0] t_act,
  output divcfg_pkg::upd_src_e upd_src
);
  import divcfg_pkg::*;

  assign upd_src = pick_source(par_lvl, par_rise, commit);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_act <= '0;
      n_act <= '0;
      t_act <= '0;
    end else begin
      unique case (upd_src)
        UPD_FLOW: begin
          m_act <= m_pin;
          n_act <= n_pin;
          t_act <= '0;
        end
        UPD_CAPTURE: begin
          m_act <= m_pin;
          n_act <= n_pin;
        end
        UPD_SERIAL: begin
          m_act <= m_f;
          n_act <= n_f;
          t_act <= t_f;
        end
        default: ;
      endcase
    end
  end

  AST_FLOW_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !par_lvl |=> (m_act == $past(m_pin)) && (n_act == $past(n_pin))); // R2
  AST_TEST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    !par_lvl |=> (t_act == '0)); // R4
  AST_CAPTURE_PINS: assert property (@(posedge clk) disable iff (rst)
    (par_lvl && par_rise) |=> (m_act == $past(m_pin)) && (n_act == $past(n_pin))); // R3
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (par_lvl && !par_rise && !commit) |=>
      $stable(m_act) && $stable(n_act) && $stable(t_act)); // R3
  AST_COMMIT_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (par_lvl && !par_rise && commit) |=>
      (t_act == $past(t_f)) && (n_act == $past(n_f)) && (m_act == $past(m_f))); // R7
  AST_PAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (!par_lvl && commit) |=> (m_act == $past(m_pin)) && (t_act == '0)); // R8

endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_load,
  input  logic [M_W-1:0] fb_pin,
  input  logic [N_W-1:0] out_pin,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_load,
  output logic [M_W-1:0] fb_div,
  output logic [N_W-1:0] out_div,
  output logic [T_W-1:0] tst_sel,
  output logic           ser_out
);
  import divcfg_pkg::*;

  localparam int STRB_W  = 3;
  localparam int IX_PAR  = 0;
  localparam int IX_SCLK = 1;
  localparam int IX_SLD  = 2;

  logic [STRB_W-1:0] strb_rise, strb_fall;
  logic              par_rise, sclk_rise, commit;
  logic [T_W-1:0]    t_f;
  logic [N_W-1:0]    n_f;
  logic [M_W-1:0]    m_f;
  upd_src_e          upd_src;

  divcfg_edge #(.W(STRB_W)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({ser_load, ser_clk, par_load}),
    .rise (strb_rise),
    .fall (strb_fall)
  );

  assign par_rise  = strb_rise[IX_PAR];
  assign sclk_rise = strb_rise[IX_SCLK];
  assign commit    = strb_fall[IX_SLD];

  divcfg_shift #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .enable (par_load),
    .step   (sclk_rise),
    .din    (ser_dat),
    .t_f    (t_f),
    .n_f    (n_f),
    .m_f    (m_f),
    .msb    (ser_out)
  );

  divcfg_active #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_active (
    .clk      (clk),
    .rst      (rst),
    .par_lvl  (par_load),
    .par_rise (par_rise),
    .commit   (commit),
    .m_pin    (fb_pin),
    .n_pin    (out_pin),
    .t_f      (t_f),
    .n_f      (n_f),
    .m_f      (m_f),
    .m_act    (fb_div),
    .n_act    (out_div),
    .t_act    (tst_sel),
    .upd_src  (upd_src)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (fb_div == '0) && (out_div == '0) && (tst_sel == '0) && !ser_out); // R1

endmodule

// File: tb/divcfg_loader_tb_top.sv
module divcfg_loader_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_load = 1'b0;
  logic [8:0] fb_pin = '0;
  logic [1:0] out_pin = '0;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       ser_load = 1'b0;
  logic [8:0] fb_div;
  logic [1:0] out_div;
  logic [2:0] tst_sel;
  logic       ser_out;

  always #10 clk = ~clk;

  divcfg_loader dut_i (
    .clk(clk), .rst(rst), .par_load(par_load), .fb_pin(fb_pin), .out_pin(out_pin),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load),
    .fb_div(fb_div), .out_div(out_div), .tst_sel(tst_sel), .ser_out(ser_out)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    started = 0;
  int    cyc_cnt = 0;

  // Behavioural reference model
  int  mdl_m, mdl_n, mdl_t;
  bit  sq[$];
  bit  pl_q, sc_q, sl_q;

  function automatic int bits_val(int first, int cnt);
    int v = 0;
    for (int i = 0; i < cnt; i++) v = v * 2 + sq[first + i];
    return v;
  endfunction

  always @(posedge clk) begin
    started = 1;
    cyc_cnt++;
    if (rst) begin
      mdl_m = 0; mdl_n = 0; mdl_t = 0;
      sq = {};
      for (int i = 0; i < 14; i++) sq.push_back(1'b0);
      pl_q = 0; sc_q = 0; sl_q = 0;
    end else begin
      if (!par_load) begin
        mdl_m = fb_pin; mdl_n = out_pin; mdl_t = 0;
      end else if (!pl_q) begin
        mdl_m = fb_pin; mdl_n = out_pin;
      end else if (!ser_load && sl_q) begin
        mdl_t = bits_val(0, 3); mdl_n = bits_val(3, 2); mdl_m = bits_val(5, 9);
      end
      if (par_load && ser_clk && !sc_q) begin
        sq.push_back(ser_dat);
        void'(sq.pop_front());
      end
      pl_q = par_load; sc_q = ser_clk; sl_q = ser_load;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      n_cmp++;
      if (fb_div !== mdl_m[8:0] || out_div !== mdl_n[1:0] ||
          tst_sel !== mdl_t[2:0] || ser_out !== sq[0]) begin
        n_bad++;
        $display("FAIL %s: got m=%h n=%h t=%h so=%b, expected m=%h n=%h t=%h so=%b",
                 cur_req, fb_div, out_div, tst_sel, ser_out,
                 mdl_m[8:0], mdl_n[1:0], mdl_t[2:0], sq[0]);
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h, expected %0h", req, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(bit b);
    ser_dat = b; ser_clk = 1'b1; step(1);
    ser_clk = 1'b0; step(1);
  endtask

  task automatic send_word(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    logic [13:0] w = {t, n, m};
    for (int i = 13; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic pulse_commit();
    ser_load = 1'b1; step(1);
    ser_load = 1'b0; step(1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc_cnt > 20000) begin
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      finish_run();
    end
  end

  initial begin
    fb_pin = 9'h155; out_pin = 2'b11;
    step(3);
    cur_req = "R1";
    chk("R1", {fb_div, out_div, tst_sel, ser_out}, 0);
    rst = 1'b0;

    cur_req = "R2";
    for (int i = 0; i < 6; i++) begin
      fb_pin = 9'(i * 73 + 5); out_pin = 2'(i);
      step(1);
      chk("R2", fb_div, i * 73 + 5);
    end
    chk("R4", tst_sel, 0);

    cur_req = "R6";
    send_word(3'b111, 2'b11, 9'h1FF);
    chk("R6", ser_out, 0);

    cur_req = "R3";
    fb_pin = 9'h0AA; out_pin = 2'b01;
    par_load = 1'b1; step(1);
    fb_pin = 9'h133; out_pin = 2'b10; step(3);
    chk("R3", fb_div, 9'h0AA);
    chk("R3", out_div, 2'b01);
    chk("R4", tst_sel, 0);

    cur_req = "R5";
    ser_bit(1'b1);
    chk("R5", ser_out, 0);
    send_word(3'b101, 2'b10, 9'h1A5);
    chk("R5", ser_out, 1);
    chk("R3", fb_div, 9'h0AA);

    cur_req = "R7";
    pulse_commit();
    chk("R7", tst_sel, 3'b101);
    chk("R7", out_div, 2'b10);
    chk("R7", fb_div, 9'h1A5);

    cur_req = "R9";
    pulse_commit();
    chk("R9", fb_div, 9'h1A5);
    chk("R9", ser_out, 1);

    cur_req = "R7";
    send_word(3'b011, 2'b01, 9'h0C3);
    pulse_commit();
    chk("R7", tst_sel, 3'b011);
    chk("R7", out_div, 2'b01);
    chk("R7", fb_div, 9'h0C3);

    cur_req = "R8";
    send_word(3'b110, 2'b11, 9'h10F);
    ser_load = 1'b1; step(1);
    fb_pin = 9'h021; out_pin = 2'b00;
    ser_load = 1'b0; par_load = 1'b0; step(1);
    chk("R8", fb_div, 9'h021);
    chk("R8", tst_sel, 0);

    cur_req = "R4";
    par_load = 1'b1; step(1);
    pulse_commit();
    chk("R7", tst_sel, 3'b110);
    par_load = 1'b0; step(1);
    chk("R4", tst_sel, 0);
    step(2);

    finish_run();
  end

endmodule